// File: doc/BRIEF.md
# SMBus Host Register and Status Controller

This block is the byte-wide register front end of an SMBus host controller. A CPU reaches it through a simple bus with read and write strobes, a 4-bit offset and 8-bit data. Software loads the command, target address, data bytes, PEC byte and mode bits. It then writes the control register with the start bit set. The block raises host busy and gives one start pulse, with the transaction parameters, to a separate protocol engine.

The engine reports the outcome through a done/error handshake. The block keeps the results as sticky status flags, which software clears by writing ones. A kill bit aborts a transaction in flight and leaves a failed flag behind.

Block data moves through a data port backed by a 32-entry buffer. With the buffer-mode bit in auxiliary control set, each port access steps through the buffer. With that bit clear, the port is a single byte, and each byte is paced by a byte-done flag that holds the engine until software clears it.

Top module: `smbh_regs`

## Requirements
- R1: After reset, status (offset 0), control (offset 2), auxiliary status (offset 12) and auxiliary control (offset 13) all read 0x00.
- R2: Offsets 3 (command), 4 (target address), 5 (data0), 6 (data1) and 8 (PEC byte) read back what was written while idle, and each drives its engine output.
- R3: A control write with bit6 set while idle sets status bit0 (busy) and pulses engStart for one cycle. engType carries control bits [5:2] and engPecEn carries control bit7. Control reads back with bit6, bit1 and bit0 at zero.
- R4: engDone while busy clears busy. With no error it sets status bit1 (complete). With engDevErr it sets bit2 and with engBusErr it sets bit3; neither error sets bit1.
- R5: A write to status clears each flag in bits 7..1 that is written as 1 and leaves the others unchanged. Bit0 (busy) cannot be written.
- R6: A control write with bit1 set while busy clears busy, sets status bit4 (failed) and pulses engKill.
- R7: While busy, a start request is ignored (no engStart). Writes to offsets 2 (other than kill), 3, 4, 5, 6, 8 and 13 have no effect.
- R8: A read of status returns bit6 (in use) as it was before the read, then sets it.
- R9: alertIn sets status bit5, which stays set until cleared by a write of 1.
- R10: With auxiliary control bit1 set, each access to offset 7 uses the current buffer entry and then advances the index by one. The index stops at 31, so a 33rd write replaces entry 31.
- R11: A read of the control register returns the buffer index to entry 0.
- R12: With auxiliary control bit1 clear, offset 7 always uses entry 0 and the index does not move. engByteDone while busy sets status bit7, and engHold stays high until bit7 is cleared.
- R13: Auxiliary control bit0 drives engCrcEn. engPecErr sets auxiliary status bit0, which is cleared by writing 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | CPU write strobe |
| busRdEn | input | 1 | CPU read strobe (read side effects apply at the clock edge) |
| busAddr | input | 4 | Register offset |
| busWrData | input | 8 | CPU write data |
| busRdData | output | 8 | CPU read data for the current offset |
| alertIn | input | 1 | Alert line event |
| engStart | output | 1 | One-cycle transaction start pulse |
| engKill | output | 1 | One-cycle abort pulse |
| engType | output | 4 | Transaction type (control bits [5:2]) |
| engPecEn | output | 1 | PEC requested for this transaction |
| engCrcEn | output | 1 | Hardware CRC enable |
| engCmd | output | 8 | Command byte |
| engSlvAdr | output | 8 | Target address byte |
| engData0 | output | 8 | Data0 byte |
| engData1 | output | 8 | Data1 byte |
| engPecVal | output | 8 | PEC byte |
| engHold | output | 1 | Byte-done handshake pending |
| engDone | input | 1 | Engine finished the transaction |
| engDevErr | input | 1 | No acknowledge from the target |
| engBusErr | input | 1 | Arbitration lost |
| engByteDone | input | 1 | One block byte finished |
| engPecErr | input | 1 | CRC mismatch detected |
| engBufWr | input | 1 | Engine write to the block buffer |
| engBufIdx | input | 5 | Engine buffer entry |
| engBufWdata | input | 8 | Engine buffer write data |
| engBufRdata | output | 8 | Buffer entry at engBufIdx |

## Verification
The bench targets the following corner cases.

- Write-one-to-clear with mixed masks, including an attempt to write busy. A design that cleared on writes of 0 would lose flags, and one that let busy be written would drop busy.
- Start and register writes issued while busy. A design without the lock would start a second transaction or corrupt the command register under the engine.
- The buffer index walked past 31 and then rewound by a control read. A design that wrapped the index would overwrite entry 0, and one that did not rewind would read out of place.
- Buffer mode turned off. A design that still advanced the index would spread single-byte traffic across the buffer.
- The in-use flag, and the error outcomes that must not set the complete flag.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
  localparam logic [3:0] A_STS  = 4'd0;
  localparam logic [3:0] A_CTL  = 4'd2;
  localparam logic [3:0] A_CMD  = 4'd3;
  localparam logic [3:0] A_ADR  = 4'd4;
  localparam logic [3:0] A_D0   = 4'd5;
  localparam logic [3:0] A_D1   = 4'd6;
  localparam logic [3:0] A_BLK  = 4'd7;
  localparam logic [3:0] A_PEC  = 4'd8;
  localparam logic [3:0] A_AUXS = 4'd12;
  localparam logic [3:0] A_AUXC = 4'd13;

  // strobes from control to datapath
  typedef struct packed {
    logic wrCmd;
    logic wrAdr;
    logic wrD0;
    logic wrD1;
    logic wrPec;
    logic wrAuxC;
    logic wrAuxS;
    logic wrBlk;
    logic rdBlk;
    logic rdCtl;
  } strobes_t;
endpackage

// File: rtl/smbh_ctrl.sv
module smbh_ctrl
  import smbh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [3:0] addr,
  input  logic [7:0] wrData,
  input  logic       alertIn,
  input  logic       engDone,
  input  logic       engDevErr,
  input  logic       engBusErr,
  input  logic       engByteDone,
  output strobes_t   strb,
  output logic [7:0] stsByte,
  output logic [7:0] ctlByte,
  output logic       engStart,
  output logic       engKill
);
  logic busy, intr, devErr, busErr, failed, alert, inUse, byteDone;
  logic [7:0] ctlReg;
  logic wrSts, wrCtl, idleWr, startReq, killReq, doneOk;

  assign wrSts    = wrEn && addr == A_STS;
  assign wrCtl    = wrEn && addr == A_CTL;
  assign idleWr   = wrEn && !busy;
  assign startReq = wrCtl && wrData[6] && !busy;
  assign killReq  = wrCtl && wrData[1] && busy;
  assign doneOk   = engDone && busy;

  always_comb begin
    strb        = '0;
    strb.wrCmd  = idleWr && addr == A_CMD;
    strb.wrAdr  = idleWr && addr == A_ADR;
    strb.wrD0   = idleWr && addr == A_D0;
    strb.wrD1   = idleWr && addr == A_D1;
    strb.wrPec  = idleWr && addr == A_PEC;
    strb.wrAuxC = idleWr && addr == A_AUXC;
    strb.wrAuxS = wrEn && addr == A_AUXS;
    strb.wrBlk  = wrEn && addr == A_BLK;
    strb.rdBlk  = rdEn && addr == A_BLK;
    strb.rdCtl  = rdEn && addr == A_CTL;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; intr <= 1'b0; devErr <= 1'b0; busErr <= 1'b0;
      failed <= 1'b0; alert <= 1'b0; inUse <= 1'b0; byteDone <= 1'b0;
      ctlReg <= '0; engStart <= 1'b0; engKill <= 1'b0;
    end else begin
      engStart <= startReq;
      engKill  <= killReq;
      if (wrCtl && !busy) ctlReg <= {wrData[7], 1'b0, wrData[5:2], 2'b00};
      // clears first, sets afterwards so a same-cycle event is kept
      if (wrSts) begin
        if (wrData[7]) byteDone <= 1'b0;
        if (wrData[6]) inUse    <= 1'b0;
        if (wrData[5]) alert    <= 1'b0;
        if (wrData[4]) failed   <= 1'b0;
        if (wrData[3]) busErr   <= 1'b0;
        if (wrData[2]) devErr   <= 1'b0;
        if (wrData[1]) intr     <= 1'b0;
      end
      if (rdEn && addr == A_STS) inUse <= 1'b1;
      if (alertIn) alert <= 1'b1;
      if (engByteDone && busy) byteDone <= 1'b1;
      if (killReq) begin
        busy   <= 1'b0;
        failed <= 1'b1;
      end else if (doneOk) begin
        busy <= 1'b0;
        if (engDevErr) devErr <= 1'b1;
        if (engBusErr) busErr <= 1'b1;
        if (!engDevErr && !engBusErr) intr <= 1'b1;
      end else if (startReq) begin
        busy <= 1'b1;
      end
    end
  end

  assign stsByte = {byteDone, inUse, alert, failed, busErr, devErr, intr, busy};
  assign ctlByte = ctlReg;

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> busy);
  p_kill_fails_r6: assert property (@(posedge clk) disable iff (!rstN)
    engKill |-> (!busy && failed));
  p_intr_clean_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intr) |-> $past(engDone && !engDevErr && !engBusErr));
  p_ctl_locked_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(ctlReg));
endmodule

// File: rtl/smbh_dpath.sv
module smbh_dpath
  import smbh_pkg::*;
#(
  parameter int BUF_DEPTH   = 32,
  parameter int DATA_W      = 8,
  parameter bit BUF_MODE_EN = 1'b1,
  localparam int IDX_W      = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [3:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] stsByte,
  input  logic [DATA_W-1:0] ctlByte,
  input  logic              engPecErr,
  input  logic              engBufWr,
  input  logic [IDX_W-1:0]  engBufIdx,
  input  logic [DATA_W-1:0] engBufWdata,
  output logic [DATA_W-1:0] engBufRdata,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] cmdReg,
  output logic [DATA_W-1:0] adrReg,
  output logic [DATA_W-1:0] d0Reg,
  output logic [DATA_W-1:0] d1Reg,
  output logic [DATA_W-1:0] pecReg,
  output logic              crcEn
);
  localparam logic [IDX_W-1:0] IDX_ONE = 1;
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(BUF_DEPTH - 1);

  logic [DATA_W-1:0] blkMem [BUF_DEPTH];
  logic [IDX_W-1:0]  blkIdx, blkPtr;
  logic              bufMode, pecErrSticky;

  generate
    if (BUF_MODE_EN) begin : g_bufmode
      logic modeReg;
      always_ff @(posedge clk) begin
        if (!rstN) modeReg <= 1'b0;
        else if (strb.wrAuxC) modeReg <= wrData[1];
      end
      assign bufMode = modeReg;
    end else begin : g_nobuf
      assign bufMode = 1'b0;
    end
  endgenerate

  assign blkPtr = bufMode ? blkIdx : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0; adrReg <= '0; d0Reg <= '0; d1Reg <= '0; pecReg <= '0;
      crcEn <= 1'b0; pecErrSticky <= 1'b0; blkIdx <= '0;
    end else begin
      if (strb.wrCmd)  cmdReg <= wrData;
      if (strb.wrAdr)  adrReg <= wrData;
      if (strb.wrD0)   d0Reg  <= wrData;
      if (strb.wrD1)   d1Reg  <= wrData;
      if (strb.wrPec)  pecReg <= wrData;
      if (strb.wrAuxC) crcEn  <= wrData[0];
      if (strb.wrAuxS && wrData[0]) pecErrSticky <= 1'b0;
      if (engPecErr) pecErrSticky <= 1'b1;
      if (strb.rdCtl) blkIdx <= '0;
      else if ((strb.wrBlk || strb.rdBlk) && bufMode && blkIdx != IDX_MAX)
        blkIdx <= blkIdx + IDX_ONE;
    end
  end

  // bus write follows the engine write so the CPU wins a same-entry clash
  always_ff @(posedge clk) begin
    if (engBufWr)   blkMem[engBufIdx] <= engBufWdata;
    if (strb.wrBlk) blkMem[blkPtr]    <= wrData;
  end

  assign engBufRdata = blkMem[engBufIdx];

  always_comb begin
    case (addr)
      A_STS:   rdData = stsByte;
      A_CTL:   rdData = ctlByte;
      A_CMD:   rdData = cmdReg;
      A_ADR:   rdData = adrReg;
      A_D0:    rdData = d0Reg;
      A_D1:    rdData = d1Reg;
      A_BLK:   rdData = blkMem[blkPtr];
      A_PEC:   rdData = pecReg;
      A_AUXS:  rdData = {{(DATA_W-1){1'b0}}, pecErrSticky};
      A_AUXC:  rdData = {{(DATA_W-2){1'b0}}, bufMode, crcEn};
      default: rdData = '0;
    endcase
  end

  p_idx_sat_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrBlk && bufMode && blkIdx == IDX_MAX) |=> blkIdx == IDX_MAX);
  p_rewind_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdCtl |=> blkIdx == '0);
  p_byte_mode_r12: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.wrBlk || strb.rdBlk) && !bufMode) |=> $stable(blkIdx));
endmodule

// File: rtl/smbh_regs.sv
module smbh_regs #(
  parameter int BUF_DEPTH   = 32,
  parameter bit BUF_MODE_EN = 1'b1,
  localparam int IDX_W      = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [3:0]       busAddr,
  input  logic [7:0]       busWrData,
  output logic [7:0]       busRdData,
  input  logic             alertIn,
  output logic             engStart,
  output logic             engKill,
  output logic [3:0]       engType,
  output logic             engPecEn,
  output logic             engCrcEn,
  output logic [7:0]       engCmd,
  output logic [7:0]       engSlvAdr,
  output logic [7:0]       engData0,
  output logic [7:0]       engData1,
  output logic [7:0]       engPecVal,
  output logic             engHold,
  input  logic             engDone,
  input  logic             engDevErr,
  input  logic             engBusErr,
  input  logic             engByteDone,
  input  logic             engPecErr,
  input  logic             engBufWr,
  input  logic [IDX_W-1:0] engBufIdx,
  input  logic [7:0]       engBufWdata,
  output logic [7:0]       engBufRdata
);
  smbh_pkg::strobes_t strb;
  logic [7:0] stsByte, ctlByte;

  smbh_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .rdEn(busRdEn), .addr(busAddr),
    .wrData(busWrData), .alertIn(alertIn), .engDone(engDone),
    .engDevErr(engDevErr), .engBusErr(engBusErr), .engByteDone(engByteDone),
    .strb(strb), .stsByte(stsByte), .ctlByte(ctlByte),
    .engStart(engStart), .engKill(engKill)
  );

  smbh_dpath #(.BUF_DEPTH(BUF_DEPTH), .DATA_W(8), .BUF_MODE_EN(BUF_MODE_EN)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(busAddr), .wrData(busWrData),
    .stsByte(stsByte), .ctlByte(ctlByte), .engPecErr(engPecErr),
    .engBufWr(engBufWr), .engBufIdx(engBufIdx), .engBufWdata(engBufWdata),
    .engBufRdata(engBufRdata), .rdData(busRdData), .cmdReg(engCmd),
    .adrReg(engSlvAdr), .d0Reg(engData0), .d1Reg(engData1),
    .pecReg(engPecVal), .crcEn(engCrcEn)
  );

  assign engType  = ctlByte[5:2];
  assign engPecEn = ctlByte[7];
  assign engHold  = stsByte[7];
endmodule

// File: tb/smbh_regs_tb_top.sv
module smbh_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 0, busRdEn = 0;
  logic [3:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic alertIn = 0, engDone = 0, engDevErr = 0, engBusErr = 0;
  logic engByteDone = 0, engPecErr = 0, engBufWr = 0;
  logic [4:0] engBufIdx = '0;
  logic [7:0] engBufWdata = '0, engBufRdata;
  logic engStart, engKill, engPecEn, engCrcEn, engHold;
  logic [3:0] engType;
  logic [7:0] engCmd, engSlvAdr, engData0, engData1, engPecVal;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  smbh_regs dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .alertIn(alertIn), .engStart(engStart), .engKill(engKill),
    .engType(engType), .engPecEn(engPecEn), .engCrcEn(engCrcEn),
    .engCmd(engCmd), .engSlvAdr(engSlvAdr), .engData0(engData0),
    .engData1(engData1), .engPecVal(engPecVal), .engHold(engHold),
    .engDone(engDone), .engDevErr(engDevErr), .engBusErr(engBusErr),
    .engByteDone(engByteDone), .engPecErr(engPecErr), .engBufWr(engBufWr),
    .engBufIdx(engBufIdx), .engBufWdata(engBufWdata), .engBufRdata(engBufRdata)
  );

  // monitor: compare each read against the scoreboard queue
  always @(negedge clk) begin
    if (busRdEn && expQ.size() > 0) begin
      logic [7:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (busRdData !== e) begin
        errors++;
        $display("FAIL %s: addr %0d actual %02h expected %02h", t, busAddr, busRdData, e);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    busWrEn = 1; busAddr = a; busWrData = d;
    @(posedge clk); #1;
    busWrEn = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    expQ.push_back(e); tagQ.push_back(tag);
    busRdEn = 1; busAddr = a;
    @(posedge clk); #1;
    busRdEn = 0;
  endtask

  task automatic done(input logic de, input logic be);
    @(posedge clk); #1;
    engDone = 1; engDevErr = de; engBusErr = be;
    @(posedge clk); #1;
    engDone = 0; engDevErr = 0; engBusErr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state, R8 in-use on second read
    rd(4'd0, 8'h00, "R1 status");
    rd(4'd0, 8'h40, "R8 in use");
    rd(4'd2, 8'h00, "R1 control");
    rd(4'd12, 8'h00, "R1 aux status");
    rd(4'd13, 8'h00, "R1 aux control");
    // R2 data registers
    wr(4'd3, 8'h3C); wr(4'd4, 8'hA5); wr(4'd5, 8'h11); wr(4'd6, 8'h22); wr(4'd8, 8'h77);
    rd(4'd3, 8'h3C, "R2 cmd"); rd(4'd4, 8'hA5, "R2 adr"); rd(4'd5, 8'h11, "R2 d0");
    rd(4'd6, 8'h22, "R2 d1"); rd(4'd8, 8'h77, "R2 pec");
    chk("R2 engCmd", engCmd, 8'h3C); chk("R2 engSlvAdr", engSlvAdr, 8'hA5);
    chk("R2 engData", {engData0[3:0], engData1[3:0]}, 8'h12);
    chk("R2 engPecVal", engPecVal, 8'h77);
    // R13 crc enable
    wr(4'd13, 8'h01);
    rd(4'd13, 8'h01, "R13 aux ctl");
    chk("R13 engCrcEn", {7'd0, engCrcEn}, 8'h01);
    // R3 start
    wr(4'd2, 8'hC8);
    chk("R3 engStart", {7'd0, engStart}, 8'h01);
    chk("R3 engType", {4'd0, engType}, 8'h02);
    chk("R3 engPecEn", {7'd0, engPecEn}, 8'h01);
    rd(4'd0, 8'h41, "R3 busy");
    rd(4'd2, 8'h88, "R3 ctl readback");
    // R7 lock while busy
    wr(4'd2, 8'h44);
    chk("R7 no restart", {7'd0, engStart}, 8'h00);
    wr(4'd3, 8'h99);
    rd(4'd3, 8'h3C, "R7 cmd locked");
    wr(4'd13, 8'h00);
    rd(4'd13, 8'h01, "R7 aux locked");
    rd(4'd2, 8'h88, "R7 ctl locked");
    // R4 clean done
    done(0, 0);
    rd(4'd0, 8'h42, "R4 complete");
    // R5 write-one-to-clear
    wr(4'd0, 8'h00); rd(4'd0, 8'h42, "R5 zero write");
    wr(4'd0, 8'h02); rd(4'd0, 8'h40, "R5 clear intr");
    wr(4'd0, 8'h41); rd(4'd0, 8'h00, "R5 busy not writable");
    wr(4'd0, 8'h40);
    // R4 error outcomes
    wr(4'd2, 8'h48); done(1, 0);
    rd(4'd0, 8'h04, "R4 dev err");
    wr(4'd0, 8'h44);
    wr(4'd2, 8'h48); done(0, 1);
    rd(4'd0, 8'h08, "R4 bus err");
    wr(4'd0, 8'h48);
    // R6 kill
    wr(4'd2, 8'h40);
    wr(4'd2, 8'h02);
    chk("R6 engKill", {7'd0, engKill}, 8'h01);
    rd(4'd0, 8'h10, "R6 failed");
    wr(4'd0, 8'h50);
    // R9 alert
    @(posedge clk); #1 alertIn = 1; @(posedge clk); #1 alertIn = 0;
    rd(4'd0, 8'h20, "R9 alert");
    wr(4'd0, 8'h60);
    rd(4'd0, 8'h00, "R9 alert cleared");
    wr(4'd0, 8'h40);
    // R13 pec error sticky
    @(posedge clk); #1 engPecErr = 1; @(posedge clk); #1 engPecErr = 0;
    rd(4'd12, 8'h01, "R13 pec err");
    wr(4'd12, 8'h01);
    rd(4'd12, 8'h00, "R13 pec err clear");
    // R10 buffer mode, saturation; R11 rewind
    wr(4'd13, 8'h02);
    rd(4'd13, 8'h02, "R10 mode on");
    rd(4'd2, 8'h00, "R11 ctl read");
    for (int i = 0; i < 33; i++) wr(4'd7, 8'(i + 1));
    rd(4'd2, 8'h00, "R11 rewind");
    for (int i = 0; i < 31; i++) rd(4'd7, 8'(i + 1), "R10 sequence");
    rd(4'd7, 8'd33, "R10 saturated entry");
    rd(4'd7, 8'd33, "R10 stays at last");
    engBufIdx = 5'd5; #1;
    chk("R10 engine view", engBufRdata, 8'd6);
    // R12 byte mode
    wr(4'd13, 8'h00);
    wr(4'd7, 8'hAB); wr(4'd7, 8'hCD);
    rd(4'd7, 8'hCD, "R12 single byte");
    rd(4'd7, 8'hCD, "R12 no advance");
    engBufIdx = 5'd1; #1;
    chk("R12 entry1 untouched", engBufRdata, 8'd2);
    wr(4'd2, 8'h54);
    @(posedge clk); #1 engByteDone = 1; @(posedge clk); #1 engByteDone = 0;
    chk("R12 hold set", {7'd0, engHold}, 8'h01);
    rd(4'd0, 8'h81, "R12 byte done");
    wr(4'd0, 8'h82);
    chk("R12 hold released", {7'd0, engHold}, 8'h00);
    rd(4'd0, 8'h41, "R12 still busy");
    done(0, 0);
    rd(4'd0, 8'h42, "R4 block complete");
    repeat (2) @(posedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule